// File: doc/BRIEF.md
# Six-Source Vectored Priority Interrupt Controller

This block sits beside a small processor core and gathers interrupt requests from six peripheral sources: an external pin or ADC completion, three timer overflows, a UART and an I2C engine. Each event sets a request flag that stays set until the interrupt is taken or software clears it. Per-source enables and one master enable gate the flags. The flags and enables are visible to software through two byte-wide control registers.

The core pulses a sampling strobe once per machine cycle. On that strobe the controller picks the highest-priority pending source and raises a call request that carries a fixed vector address. The request and its vector behave like a valid/ready pair: once raised, the request stays high and the vector stays stable until the core acknowledges it. The acknowledge clears the serviced flag and the master enable in the same edge, so the handler runs with interrupts blocked. An interrupt-return strobe turns the master enable back on. A plain-return strobe does not. A stack-full input from the core stops any new dispatch.

Top module: `ic_vectored_irq`

## Requirements
- R1: After reset, all six flags, all six enables and the master enable are 0, `irq_req` is 0, and both control registers read 0.
- R2: A one-cycle pulse on `src_evt[i]` sets flag i at the next edge. The flag stays set until it is acknowledged or written to 0. Bit 4 (I2C) is also set by `i2c_addr_match` or by `i2c_byte_done`.
- R3: The register at address 0x0B holds sources 0..2 and the register at 0x1E holds sources 3..5. In each register, bits [2:0] are the enables of its three sources, lowest source in bit 0, and bits [6:4] are their flags, lowest source in bit 4. Bit 3 of 0x0B is the master enable. All other bits read 0, and any other address reads 0. A write replaces the enables and flags of that register, and bit 3 of 0x0B, at the next edge.
- R4: When a peripheral event and a write or acknowledge that clears the same flag fall in the same cycle, the flag ends up set.
- R5: A request is raised only on a `sample_strobe` edge, and only when some source has both its flag and its enable set, the master enable is 1 and `stack_full` is 0. `irq_req` is high after that edge.
- R6: The source with the lowest index wins. The vector is 4 + 4*index, which gives 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18.
- R7: While `irq_req` is high and `irq_ack` is low, `irq_req` and `irq_vec` hold, even across further strobes. An edge with both high clears the flag of the granted source and the master enable, and drops `irq_req`. `irq_ack` has no effect while `irq_req` is low.
- R8: A pulse on `ret_irq` sets the master enable at the next edge. A pulse on `ret_plain` leaves it unchanged.
- R9: Requests that arrive while the master enable is 0 stay pending. They are dispatched on the first strobe after the master enable returns to 1.
- R10: While `stack_full` is 1, a strobe raises no request. Pending flags remain set.
- R11: An event on the same edge as a strobe is not seen by that strobe. It is serviced on the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 6 | Per-source event pulses; index 0 has the highest priority |
| i2c_addr_match | input | 1 | I2C slave address match event |
| i2c_byte_done | input | 1 | I2C one-byte transfer complete event |
| sample_strobe | input | 1 | Core sampling-phase pulse |
| stack_full | input | 1 | Core call stack is full |
| reg_wr | input | 1 | Control register write strobe |
| reg_addr | input | 8 | Control register address |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data (combinational) |
| irq_req | output | 1 | Call request (valid) |
| irq_vec | output | 5 | Vector address of the granted source |
| irq_ack | input | 1 | Core accepts the call (ready) |
| ret_irq | input | 1 | Interrupt-return instruction executed |
| ret_plain | input | 1 | Ordinary return instruction executed |

## Verification
Events, register writes, acknowledges and return strobes all act at the first clock edge after they are driven. Read data is combinational. `irq_req` and `irq_vec` change at the edge that samples the strobe. The bench drives every input on the falling edge and holds it through exactly one rising edge. It samples outputs and read-back values on the following falling edge, so every result is checked one edge after its stimulus, or zero edges after for reads. The flag and enable sweeps each walk all 64 patterns, and the expected winner and vector are computed arithmetically in the bench.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int N_SRC     = 6;
  localparam int SLOTS     = 3;   // sources per control register
  localparam int N_REGS    = N_SRC / SLOTS;
  localparam int VEC_W     = 5;
  localparam int VEC_BASE  = 4;
  localparam int VEC_STEP  = 4;
  localparam int EN_LSB    = 0;
  localparam int ME_BIT    = 3;
  localparam int FLAG_LSB  = 4;
  localparam int I2C_IDX   = 4;

  typedef logic [N_SRC-1:0] src_vec_t;

  // vector address of a one-hot grant
  function automatic logic [VEC_W-1:0] vec_of(input src_vec_t g);
    logic [VEC_W-1:0] v;
    v = '0;
    for (int i = 0; i < N_SRC; i++)
      if (g[i]) v = v | VEC_W'(VEC_BASE + VEC_STEP * i);
    return v;
  endfunction
endpackage

// File: rtl/ic_ctrl_regs.sv
module ic_ctrl_regs
  import ic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG0_ADDR = 8'h0B,
  parameter logic [ADDR_W-1:0] REG1_ADDR = 8'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  src_vec_t          evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ack_fire,
  input  src_vec_t          ack_sel,
  input  logic              ret_irq,
  input  logic              ret_plain,
  output src_vec_t          flags,
  output src_vec_t          enables,
  output logic              master_en
);
  logic [N_REGS-1:0] hit;
  logic [N_REGS-1:0] rsel;
  src_vec_t          flag_nx, en_nx, ack_clr;
  logic              me_nx;
  logic [DATA_W-1:0] img [N_REGS];
  logic              unused_bits;

  assign rsel[0] = (addr == REG0_ADDR);
  assign rsel[1] = (addr == REG1_ADDR);
  assign hit     = wr_en ? rsel : '0;
  assign ack_clr = ack_fire ? ack_sel : '0;
  assign unused_bits = ^wdata[DATA_W-1:FLAG_LSB+SLOTS];

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam int K = i / SLOTS;
    localparam int S = i % SLOTS;
    // a coinciding event always wins over any clear
    assign flag_nx[i] = evt[i] |
      (hit[K] ? wdata[FLAG_LSB+S] : (flags[i] & ~ack_clr[i]));
    assign en_nx[i] = hit[K] ? wdata[EN_LSB+S] : enables[i];
  end

  always_comb begin
    if (ack_fire)     me_nx = 1'b0;
    else if (ret_irq) me_nx = 1'b1;
    else if (hit[0])  me_nx = wdata[ME_BIT];
    else              me_nx = master_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '0;
      enables   <= '0;
      master_en <= 1'b0;
    end else begin
      flags     <= flag_nx;
      enables   <= en_nx;
      master_en <= me_nx;
    end
  end

  always_comb begin
    for (int k = 0; k < N_REGS; k++) begin
      img[k] = '0;
      for (int s = 0; s < SLOTS; s++) begin
        img[k][EN_LSB+s]   = enables[k*SLOTS+s];
        img[k][FLAG_LSB+s] = flags[k*SLOTS+s];
      end
    end
    img[0][ME_BIT] = master_en;
    rdata = '0;
    for (int k = 0; k < N_REGS; k++)
      if (rsel[k]) rdata = img[k];
  end

  AST_ACK_DROPS_ME: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !master_en); // R7
  AST_RETI_SETS_ME: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_irq && !ack_fire) |=> master_en); // R8
  AST_RET_KEEPS_ME: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_plain && !ret_irq && !ack_fire && !hit[0]) |=> (master_en == $past(master_en))); // R8
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt))); // R4
endmodule

// File: rtl/ic_prio_pick.sv
module ic_prio_pick
  import ic_pkg::*;
(
  input  src_vec_t flags,
  input  src_vec_t enables,
  output src_vec_t grant,
  output logic     any_pend
);
  src_vec_t pend;
  assign pend     = flags & enables;
  assign any_pend = |pend;

  for (genvar i = 0; i < N_SRC; i++) begin : g_prio
    if (i == 0) begin : g_top
      assign grant[i] = pend[i];
    end else begin : g_rest
      assign grant[i] = pend[i] & ~(|pend[i-1:0]);
    end
  end
endmodule

// File: rtl/ic_dispatch.sv
module ic_dispatch
  import ic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             stack_full,
  input  logic             master_en,
  input  logic             any_pend,
  input  src_vec_t         grant,
  input  logic             ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output src_vec_t         sel,
  output logic             ack_fire
);
  logic go;
  assign ack_fire = ack & irq_req;
  assign go       = strobe & ~irq_req & master_en & ~stack_full & any_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      sel     <= '0;
    end else if (ack_fire) begin
      irq_req <= 1'b0;
    end else if (go) begin
      irq_req <= 1'b1;
      irq_vec <= vec_of(grant);
      sel     <= grant;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !ack) |=> (irq_req && $stable(irq_vec))); // R7
  AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(strobe) && $past(master_en) && !$past(stack_full))); // R5
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $onehot(sel)); // R6
endmodule

// File: rtl/ic_vectored_irq.sv
module ic_vectored_irq
  import ic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG0_ADDR = 8'h0B,
  parameter logic [ADDR_W-1:0] REG1_ADDR = 8'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic              i2c_addr_match,
  input  logic              i2c_byte_done,
  input  logic              sample_strobe,
  input  logic              stack_full,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack,
  input  logic              ret_irq,
  input  logic              ret_plain
);
  src_vec_t evt, flags, enables, grant, sel;
  logic     master_en, any_pend, ack_fire;

  always_comb begin
    evt = src_evt;
    evt[I2C_IDX] = src_evt[I2C_IDX] | i2c_addr_match | i2c_byte_done;
  end

  ic_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REG0_ADDR(REG0_ADDR), .REG1_ADDR(REG1_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .ack_fire(ack_fire), .ack_sel(sel),
    .ret_irq(ret_irq), .ret_plain(ret_plain),
    .flags(flags), .enables(enables), .master_en(master_en)
  );

  ic_prio_pick u_pick (
    .flags(flags), .enables(enables), .grant(grant), .any_pend(any_pend)
  );

  ic_dispatch u_disp (
    .clk(clk), .rst_n(rst_n), .strobe(sample_strobe), .stack_full(stack_full),
    .master_en(master_en), .any_pend(any_pend), .grant(grant), .ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec), .sel(sel), .ack_fire(ack_fire)
  );

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec >= VEC_W'(VEC_BASE) && irq_vec[1:0] == 2'b00 &&
                 irq_vec <= VEC_W'(VEC_BASE + VEC_STEP*(N_SRC-1)))); // R6
endmodule

// File: tb/sim_ic_vectored_irq.sv
module sim_ic_vectored_irq;
  logic       clk = 0, rst_n = 0;
  logic [5:0] src_evt = '0;
  logic       i2c_addr_match = 0, i2c_byte_done = 0;
  logic       sample_strobe = 0, stack_full = 0;
  logic       reg_wr = 0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic       irq_req;
  logic [4:0] irq_vec;
  logic       irq_ack = 0, ret_irq = 0, ret_plain = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ic_vectored_irq u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic strobe(); sample_strobe = 1; tick(); sample_strobe = 0; endtask
  task automatic ack();    irq_ack = 1; tick(); irq_ack = 0; endtask
  task automatic evt(input logic [5:0] e); src_evt = e; tick(); src_evt = '0; endtask

  function automatic int low(input logic [5:0] p);
    int l = 0;
    for (int i = 5; i >= 0; i--) if (p[i]) l = i;
    return l;
  endfunction

  function automatic logic [7:0] img(input logic [2:0] f, input bit me, input logic [2:0] e);
    return {1'b0, f, me, e};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic [5:0] q;
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    rd(8'h0B, d); chk(d == 0, "R1 reg 0x0B", d, 0);
    rd(8'h1E, d); chk(d == 0, "R1 reg 0x1E", d, 0);
    chk(irq_req == 0, "R1 irq_req", irq_req, 0);

    // R2 events set sticky flags, incl. both I2C sources
    for (int i = 0; i < 6; i++) begin
      evt(6'(1 << i)); repeat (3) tick();
      rd(8'h0B, d); rd(8'h1E, d2);
      chk({d2[6:4], d[6:4]} == 6'(1 << i), "R2 sticky flag", {d2[6:4], d[6:4]}, 1 << i);
      wr(8'h0B, 0); wr(8'h1E, 0);
    end
    i2c_addr_match = 1; tick(); i2c_addr_match = 0;
    rd(8'h1E, d); chk(d == 8'h20, "R2 i2c addr match", d, 8'h20);
    wr(8'h1E, 0);
    i2c_byte_done = 1; tick(); i2c_byte_done = 0;
    rd(8'h1E, d); chk(d == 8'h20, "R2 i2c byte done", d, 8'h20);
    // R3 unmapped address reads 0, bit 7 reads 0
    wr(8'h1E, 8'hFF); rd(8'h1E, d); chk(d == 8'h77, "R3 reg 0x1E write", d, 8'h77);
    rd(8'h0C, d); chk(d == 0, "R3 unmapped read", d, 0);
    // R4 event vs write-clear same cycle
    src_evt = 6'b010000; reg_wr = 1; reg_addr = 8'h1E; reg_wdata = 8'h00; tick();
    src_evt = 0; reg_wr = 0;
    rd(8'h1E, d); chk(d == 8'h20, "R4 event beats write clear", d, 8'h20);
    wr(8'h1E, 0);

    // R5 R6 R7 flag sweep with all enables and master on
    for (int p = 0; p < 64; p++) begin
      wr(8'h0B, img(p[2:0], 1, 3'b111)); wr(8'h1E, img(p[5:3], 0, 3'b111));
      tick(); chk(irq_req == 0, "R5 no strobe no request", irq_req, 0);
      strobe();
      chk(irq_req == (p != 0), "R5 request on strobe", irq_req, p != 0);
      if (p != 0) begin
        chk(irq_vec == 4 + 4 * low(p), "R6 vector", irq_vec, 4 + 4 * low(p));
        ack();
        q = 6'(p) & ~6'(1 << low(p));
        chk(irq_req == 0, "R7 ack drops request", irq_req, 0);
        rd(8'h0B, d); chk(d == img(q[2:0], 0, 3'b111), "R7 ack clears flag and master", d, img(q[2:0], 0, 3'b111));
        rd(8'h1E, d); chk(d == img(q[5:3], 0, 3'b111), "R7 ack clears flag", d, img(q[5:3], 0, 3'b111));
      end
    end

    // R6 enable sweep with all flags set
    for (int e = 0; e < 64; e++) begin
      wr(8'h0B, img(3'b111, 1, e[2:0])); wr(8'h1E, img(3'b111, 0, e[5:3]));
      strobe();
      chk(irq_req == (e != 0), "R5 enable gating", irq_req, e != 0);
      if (e != 0) begin
        chk(irq_vec == 4 + 4 * low(e), "R6 vector by enable", irq_vec, 4 + 4 * low(e));
        ack();
      end
    end

    // R5 master off blocks
    wr(8'h0B, img(3'b111, 0, 3'b111)); strobe();
    chk(irq_req == 0, "R5 master off", irq_req, 0);

    // R7 hold across strobes; ack ignored when idle
    wr(8'h0B, img(3'b000, 1, 3'b111)); wr(8'h1E, img(3'b100, 0, 3'b111));
    ack();
    rd(8'h0B, d); chk(d == img(0, 1, 3'b111), "R7 idle ack ignored", d, img(0, 1, 3'b111));
    strobe(); chk(irq_vec == 5'h18, "R6 lowest source vector", irq_vec, 5'h18);
    evt(6'b000001); strobe(); strobe();
    chk(irq_req == 1 && irq_vec == 5'h18, "R7 hold until ack", irq_vec, 5'h18);
    ack();
    // R8 plain return keeps master off, interrupt return sets it
    ret_plain = 1; tick(); ret_plain = 0;
    rd(8'h0B, d); chk(d[3] == 0, "R8 plain return", d[3], 0);
    // R9 pending while handler runs
    strobe(); chk(irq_req == 0, "R9 blocked during handler", irq_req, 0);
    ret_irq = 1; tick(); ret_irq = 0;
    rd(8'h0B, d); chk(d[3] == 1, "R8 interrupt return", d[3], 1);
    strobe(); chk(irq_req == 1 && irq_vec == 5'h04, "R9 pending dispatched", irq_vec, 5'h04);
    ack(); ret_irq = 1; tick(); ret_irq = 0;

    // R10 stack full blocks
    evt(6'b000010); stack_full = 1; strobe();
    chk(irq_req == 0, "R10 stack full", irq_req, 0);
    rd(8'h0B, d); chk(d[5] == 1, "R10 flag kept", d[5], 1);
    stack_full = 0; strobe();
    chk(irq_req == 1 && irq_vec == 5'h08, "R10 after stack frees", irq_vec, 5'h08);
    ack(); ret_irq = 1; tick(); ret_irq = 0;

    // R11 event coinciding with strobe waits for the next strobe
    src_evt = 6'b001000; sample_strobe = 1; tick(); src_evt = 0; sample_strobe = 0;
    chk(irq_req == 0, "R11 same-edge event not seen", irq_req, 0);
    strobe(); chk(irq_req == 1 && irq_vec == 5'h10, "R11 next strobe", irq_vec, 5'h10);
    // R4 event beats ack clear on same source
    src_evt = 6'b001000; irq_ack = 1; tick(); src_evt = 0; irq_ack = 0;
    rd(8'h1E, d); chk(d[4] == 1, "R4 event beats ack clear", d[4], 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule